// File: doc/BRIEF.md
# Write-Protected Startup Configuration Register

This block keeps the two startup configuration bits of a small microcontroller: a watchdog-disable bit and a ROM-enable bit. It also decides when software may change them. The block sits on a simple register bus made of an address, a write strobe, write data and combinational read data. A separate one-cycle bus tick marks each bus cycle. The two stored bits are driven straight out to the watchdog and to the memory-map decoder. Neither of those is part of this block.

In normal operation, protection limits what software can do after each reset. A write succeeds only if it arrives before a fixed number of bus ticks has elapsed, and only the first such write counts. In special mode, both limits are lifted, so the register can be rewritten freely. Leaving special mode keeps the elapsed tick count and the used-write state. Software should therefore program the register before it clears the special-mode input.

Top module: `startup_cfg_reg`

## Requirements
- R1: While `rst` is high at a clock edge, the stored bits take their reset values: ROM enable is 1 and watchdog disable is 0. A read at offset 0x3F afterwards returns 0x02.
- R2: In normal mode, a write to offset 0x3F is accepted while fewer than 64 bus ticks have been seen since reset. Write data bit 2 goes to watchdog disable and bit 1 goes to ROM enable. The new values appear on the outputs from the next clock.
- R3: In normal mode, only the first accepted write after a reset takes effect. Any later write leaves the bits unchanged, even when it falls inside the tick window.
- R4: In normal mode, once 64 bus ticks have been counted since reset, writes are ignored. A write in the cycle that carries the 64th tick is still accepted.
- R5: With `special_mode` high, writes to offset 0x3F are accepted at any time and any number of times. These writes do not use up the single normal-mode write.
- R6: Read data bits 7 to 3 and bit 0 are always zero. Read bit 2 shows watchdog disable and read bit 1 shows ROM enable, with no side effects.
- R7: A write to any offset other than 0x3F changes nothing and does not use up the single write. A read at such an offset returns zero.
- R8: Every reset restarts the tick window from zero and clears the used-write state.
- R9: When `special_mode` falls, the ticks already counted and the used-write state carry over into normal mode unchanged.
- R10: Only clock cycles with `bus_tick` high advance the window. Idle clock cycles do not close it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| special_mode | input | 1 | 1 lifts the write protection |
| bus_tick | input | 1 | One-cycle pulse per bus cycle |
| addr | input | 6 | Register offset |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr`, combinational |
| wdog_disable | output | 1 | Stored watchdog-disable bit |
| rom_enable | output | 1 | Stored ROM-enable bit |

## Verification
Writes are placed at tick counts 0, 63 and 64 to separate an off-by-one window from a correct one. A run of idle clocks with no ticks shows that the window counts bus cycles and not clocks. Back-to-back writes in normal mode, in special mode, and across a fall of `special_mode` separate the single-write limit from the window limit and show which state carries over. Writes to a neighbouring offset, and data with every bit set, show that decoding is correct and that unused bits stay at zero.

// File: rtl/startup_cfg_pkg.sv
package startup_cfg_pkg;

    parameter int DATA_W       = 8;
    parameter int ADDR_W       = 6;
    parameter int CFG_OFFSET   = 'h3F;
    parameter int WINDOW_TICKS = 64;
    parameter int WDOG_BIT     = 2;
    parameter int ROM_BIT      = 1;

    typedef struct packed {
        logic wdog_off;
        logic rom_on;
    } cfg_bits_t;

    localparam cfg_bits_t CFG_RESET = '{wdog_off: 1'b0, rom_on: 1'b1};

    function automatic logic [DATA_W-1:0] cfg_to_bus(input cfg_bits_t c);
        logic [DATA_W-1:0] v;
        v = '0;
        v[WDOG_BIT] = c.wdog_off;
        v[ROM_BIT]  = c.rom_on;
        return v;
    endfunction

    function automatic cfg_bits_t bus_to_cfg(input logic [DATA_W-1:0] d);
        cfg_bits_t c;
        c.wdog_off = d[WDOG_BIT];
        c.rom_on   = d[ROM_BIT];
        return c;
    endfunction

endpackage

// File: rtl/cfg_guard_window.sv
module cfg_guard_window #(
    parameter int WINDOW_TICKS = startup_cfg_pkg::WINDOW_TICKS
) (
    input  logic clk,
    input  logic rst,
    input  logic bus_tick,
    input  logic special_mode,
    input  logic wr_hit,
    output logic wr_grant
);
    localparam int CNT_W = $clog2(WINDOW_TICKS + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WINDOW_TICKS);

    logic [CNT_W-1:0] tick_cnt;
    logic             used_q;
    logic             window_open;

    assign window_open = (tick_cnt < CNT_LAST);
    assign wr_grant    = wr_hit && (special_mode || (window_open && !used_q));

    always_ff @(posedge clk) begin
        if (rst) begin
            tick_cnt <= '0;
        end else if (bus_tick && window_open) begin
            tick_cnt <= tick_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            used_q <= 1'b0;
        end else if (wr_grant && !special_mode) begin
            used_q <= 1'b1;
        end
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        tick_cnt <= CNT_LAST);  // R4
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !bus_tick |=> $stable(tick_cnt));  // R10
    AST_USED_STICKY: assert property (@(posedge clk) disable iff (rst)
        used_q |=> used_q);  // R3
    AST_NO_LATE_GRANT: assert property (@(posedge clk) disable iff (rst)
        (!special_mode && !window_open) |-> !wr_grant);  // R4
    AST_SPECIAL_GRANT: assert property (@(posedge clk) disable iff (rst)
        (special_mode && wr_hit) |-> wr_grant);  // R5
endmodule

// File: rtl/cfg_bit_store.sv
module cfg_bit_store
    import startup_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_grant,
    input  logic [DATA_W-1:0] wr_data,
    output cfg_bits_t         bits_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            bits_q <= CFG_RESET;
        end else if (wr_grant) begin
            bits_q <= bus_to_cfg(wr_data);
        end
    end

    AST_HOLD_NO_GRANT: assert property (@(posedge clk) disable iff (rst)
        !wr_grant |=> $stable(bits_q));  // R3
    AST_RESET_VALUE: assert property (@(posedge clk)
        rst |=> (bits_q.rom_on && !bits_q.wdog_off));  // R1
endmodule

// File: rtl/cfg_read_port.sv
module cfg_read_port
    import startup_cfg_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  cfg_bits_t         bits_q,
    output logic [DATA_W-1:0] rd_data
);
    localparam logic [ADDR_W-1:0] SEL = ADDR_W'(CFG_OFFSET);

    always_comb begin
        rd_data = '0;
        if (addr == SEL) begin
            rd_data = cfg_to_bus(bits_q);
        end
    end

    always_comb begin
        AST_UNUSED_ZERO: assert (rd_data[DATA_W-1:WDOG_BIT+1] == '0 && rd_data[0] == 1'b0);  // R6
    end
endmodule

// File: rtl/startup_cfg_reg.sv
module startup_cfg_reg
    import startup_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              special_mode,
    input  logic              bus_tick,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              wdog_disable,
    output logic              rom_enable
);
    localparam logic [ADDR_W-1:0] SEL = ADDR_W'(CFG_OFFSET);

    logic      wr_hit;
    logic      wr_grant;
    cfg_bits_t bits_q;

    assign wr_hit = wr_en && (addr == SEL);

    cfg_guard_window #(.WINDOW_TICKS(WINDOW_TICKS)) u_window (
        .clk          (clk),
        .rst          (rst),
        .bus_tick     (bus_tick),
        .special_mode (special_mode),
        .wr_hit       (wr_hit),
        .wr_grant     (wr_grant)
    );

    cfg_bit_store u_store (
        .clk      (clk),
        .rst      (rst),
        .wr_grant (wr_grant),
        .wr_data  (wr_data),
        .bits_q   (bits_q)
    );

    cfg_read_port u_read (
        .addr    (addr),
        .bits_q  (bits_q),
        .rd_data (rd_data)
    );

    assign wdog_disable = bits_q.wdog_off;
    assign rom_enable   = bits_q.rom_on;

    AST_OTHER_ADDR: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr != SEL) |=> ($stable(wdog_disable) && $stable(rom_enable)));  // R7
    AST_ROM_OUT_RESET: assert property (@(posedge clk)
        rst |=> (rom_enable && !wdog_disable));  // R1
endmodule

// File: tb/startup_cfg_reg_test.sv
module startup_cfg_reg_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       special_mode = 1'b0;
    logic       bus_tick = 1'b0;
    logic [5:0] addr = 6'h3F;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       wdog_disable, rom_enable;

    int n_checks = 0;
    int n_fails  = 0;

    int m_cnt = 0;
    bit m_used = 0;
    bit m_wd = 0;
    bit m_rom = 1;

    always #2.5 clk = ~clk;

    startup_cfg_reg uut (
        .clk(clk), .rst(rst), .special_mode(special_mode), .bus_tick(bus_tick),
        .addr(addr), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .wdog_disable(wdog_disable), .rom_enable(rom_enable)
    );

    // behavioural reference, advanced on each rising edge
    always @(posedge clk) begin
        bit acc;
        if (rst) begin
            m_cnt = 0; m_used = 0; m_wd = 0; m_rom = 1;
        end else begin
            acc = wr_en && addr == 6'h3F && (special_mode || (m_cnt < 64 && !m_used));
            if (acc) begin
                m_wd = wr_data[2]; m_rom = wr_data[1];
                if (!special_mode) m_used = 1;
            end
            if (bus_tick && m_cnt < 64) m_cnt++;
        end
    end

    // per-cycle comparison against the reference
    always @(negedge clk) begin
        logic [7:0] exp_rd;
        exp_rd = (addr == 6'h3F) ? {5'b0, m_wd, m_rom, 1'b0} : 8'h00;
        n_checks++;
        if (rd_data !== exp_rd || wdog_disable !== m_wd || rom_enable !== m_rom) begin
            n_fails++;
            $display("FAIL R2/R3 model: rd=%h wd=%b rom=%b expected rd=%h wd=%b rom=%b",
                     rd_data, wdog_disable, rom_enable, exp_rd, m_wd, m_rom);
        end
    end

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(posedge clk) #1;
    endtask

    task automatic do_reset(input bit sp);
        @(posedge clk) #1;
        rst = 1'b1; special_mode = sp; wr_en = 0; bus_tick = 0;
        step(2);
        rst = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            bus_tick = 1'b1; step(1);
        end
        bus_tick = 1'b0;
    endtask

    task automatic wr(input logic [5:0] a, input logic [7:0] d, input bit tk);
        addr = a; wr_data = d; wr_en = 1'b1; bus_tick = tk;
        step(1);
        wr_en = 1'b0; bus_tick = 1'b0; addr = 6'h3F;
    endtask

    task automatic rd(input string tag, input logic [5:0] a, input logic [7:0] exp);
        addr = a; #0.5;
        check(tag, rd_data, exp);
        addr = 6'h3F;
    endtask

    initial begin
        #1_000_000;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        step(3);
        rst = 1'b0;
        rd("R1 reset value", 6'h3F, 8'h02);
        check("R1 rom_enable", {7'b0, rom_enable}, 8'h01);
        check("R1 wdog_disable", {7'b0, wdog_disable}, 8'h00);

        // R2 and R6: first write inside the window, all data bits set
        wr(6'h3F, 8'hFF, 1'b1);
        rd("R2 accepted write", 6'h3F, 8'h06);
        rd("R6 unused bits zero", 6'h3F, 8'h06);
        // R3: second write ignored
        wr(6'h3F, 8'h00, 1'b1);
        rd("R3 second write ignored", 6'h3F, 8'h06);

        // R8: reset reopens the window and clears the used state
        do_reset(0);
        rd("R8 reset restores", 6'h3F, 8'h02);
        ticks(63);
        // R4: write carrying the 64th tick still accepted
        wr(6'h3F, 8'h04, 1'b1);
        rd("R4 last window cycle", 6'h3F, 8'h04);

        do_reset(0);
        ticks(64);
        wr(6'h3F, 8'h04, 1'b0);
        rd("R4 closed window ignored", 6'h3F, 8'h02);

        // R10: idle clocks do not advance the window
        do_reset(0);
        step(150);
        ticks(10);
        wr(6'h3F, 8'h04, 1'b0);
        rd("R10 idle clocks not counted", 6'h3F, 8'h04);

        // R7: other offsets ignored and do not consume the write
        do_reset(0);
        wr(6'h3E, 8'h04, 1'b1);
        rd("R7 other offset no effect", 6'h3F, 8'h02);
        rd("R7 other offset reads zero", 6'h3E, 8'h00);
        wr(6'h3F, 8'h06, 1'b1);
        rd("R7 write still available", 6'h3F, 8'h06);

        // R5: special mode accepts repeated and late writes
        do_reset(1);
        ticks(200);
        wr(6'h3F, 8'h04, 1'b1);
        rd("R5 late special write", 6'h3F, 8'h04);
        wr(6'h3F, 8'h02, 1'b1);
        rd("R5 repeated special write", 6'h3F, 8'h02);
        wr(6'h3F, 8'hF9, 1'b0);
        rd("R5 third special write", 6'h3F, 8'h00);
        // R9: expired window carries into normal mode
        special_mode = 1'b0;
        wr(6'h3F, 8'h06, 1'b0);
        rd("R9 expired window carried", 6'h3F, 8'h00);

        // R5/R9: special writes do not consume; remaining time carries over
        do_reset(1);
        ticks(10);
        wr(6'h3F, 8'h00, 1'b1);
        special_mode = 1'b0;
        ticks(10);
        wr(6'h3F, 8'h06, 1'b1);
        rd("R9 remaining window after special", 6'h3F, 8'h06);
        wr(6'h3F, 8'h00, 1'b1);
        rd("R3 single write after special", 6'h3F, 8'h06);

        step(2);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end
endmodule